// File: doc/BRIEF.md
# Level-Sensitive Interrupt Collector with Global Gate

This block gathers one-cycle event strobes from a peripheral into two sticky status registers: a 32-bit main register and a 16-bit DMA-reason register. Every status bit has an individual enable, supplied as an input mask. The block drives one active-low interrupt line, `irq_n`. A global-enable bit in a small control register gates when the line may first assert. Once the line is low, it stays low until no enabled status bit is pending in either register. Dropping the global enable alone never releases it.

Software reads the registers and clears them over a plain register bus. Each access selects a register with `bus_addr` and qualifies its byte lanes with `bus_be`:

| Address | Register |
|---|---|
| 0 | Main status |
| 1 | DMA reason |
| 2 | Control (bit 0 is the global enable) |

Status bits are write-one-to-clear. A clear only takes effect when the write covers every byte lane of the target register. A write that covers only some of the lanes is discarded.

The bus carries control and status only, so it has no valid/ready handshake. A write completes in the cycle `bus_wr` is high. A read is combinational from the current register contents.

Top module: `irq_aggregator`

## Requirements
- R1: After reset both status registers read 0, the control register reads 0 and `irq_n` is 1.
- R2: An event strobe bit sets its status bit at the next clock edge whatever the global enable is. While the global enable is 0 and the line is not already low, `irq_n` stays 1.
- R3: With `bus_addr` set to 0, 1 or 2, `bus_rdata` shows that register in the same cycle. The DMA register is zero-extended in bits 31:16, and the control register shows the global enable in bit 0 with 0 in the other bits.
- R4: A write to a status register with all of its byte lanes enabled clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to a status register that leaves any of its byte lanes disabled changes no status bit. The main register has lanes 3:0 and the DMA register has lanes 1:0.
- R6: An event on a bit in the same cycle as a clear of that bit leaves the bit set.
- R7: When the global enable is 1 and any status bit is set with its individual enable set, `irq_n` is 0. This includes the first cycle after the global enable is written to 1.
- R8: A set status bit whose individual enable is 0 never drives `irq_n` low.
- R9: Writing the global enable to 0 while `irq_n` is 0 leaves `irq_n` at 0 for as long as an enabled status bit remains set.
- R10: `irq_n` returns to 1 in the cycle after the last enabled pending bit is cleared, whichever register held it. It does not return while enabled bits remain in the other register.
- R11: Once the line has returned to 1 with the global enable at 0, enabled pending bits do not drive it low again until the global enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_evt | input | 32 | One-cycle event strobes for the main status register (bit 0 used for start-of-frame) |
| dma_evt | input | 16 | One-cycle event strobes for the DMA-reason register |
| main_en | input | 32 | Individual enables for main status bits |
| dma_en | input | 16 | Individual enables for DMA-reason bits |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 main, 1 DMA, 2 control |
| bus_be | input | 4 | Byte-lane enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq_n | output | 1 | Interrupt line, low when asserted |

## Verification
The checker checks on every cycle that each strobe leaves its bit set, including against a simultaneous clear. It also checks that a partial-lane write leaves the register unchanged, that a full write clears exactly the written ones, and that the line is low whenever the gate and an enabled bit coincide. It further checks that the line is never low without an enabled pending bit, and that a low line with pending work stays low.

The bench's scenarios show the behaviours that depend on a history of steps. These are:
- the register contents seen through the read port;
- the sticky hold across a drop of the global enable;
- release only after both registers are drained;
- no re-assertion after a release while the gate is closed.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_DMA  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_go,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] en,
  output logic [W-1:0] stat,
  output logic         req
);
  logic [W-1:0] clr_eff;

  always_comb clr_eff = clr_go ? clr_mask : '0;

  // A strobe in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_eff) | evt;
  end

  always_comb req = |(stat & en);
endmodule

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_main,
  input  logic req_dma,
  input  logic glb_en,
  output logic asserted,
  output logic irq_n
);
  logic any_req;
  logic hold_q;

  always_comb begin
    any_req  = req_main | req_dma;
    asserted = any_req & (glb_en | hold_q);
    irq_n    = ~asserted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= asserted;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned MAIN_W = 32,
  parameter int unsigned DMA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAIN_W-1:0] main_evt,
  input  logic [DMA_W-1:0]  dma_evt,
  input  logic [MAIN_W-1:0] main_en,
  input  logic [DMA_W-1:0]  dma_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [MAIN_W/8-1:0] bus_be,
  input  logic [MAIN_W-1:0] bus_wdata,
  output logic [MAIN_W-1:0] bus_rdata,
  output logic              irq_n
);
  import irq_agg_pkg::*;

  localparam int unsigned MAIN_NB = MAIN_W / LANE_W;
  localparam int unsigned DMA_NB  = DMA_W / LANE_W;

  logic [MAIN_W-1:0] main_stat;
  logic [DMA_W-1:0]  dma_stat;
  logic              main_req, dma_req;
  logic              glb_en;
  logic              any_req;
  logic              pin_asserted;
  logic              main_clr, dma_clr;
  reg_sel_e          sel;

  always_comb begin
    sel      = reg_sel_e'(bus_addr);
    main_clr = bus_wr && (sel == SEL_MAIN) && (&bus_be[MAIN_NB-1:0]);
    dma_clr  = bus_wr && (sel == SEL_DMA)  && (&bus_be[DMA_NB-1:0]);
    any_req  = main_req | dma_req;
  end

  irq_status_reg #(.W(MAIN_W)) u_main (
    .clk(clk), .rst_n(rst_n), .evt(main_evt), .clr_go(main_clr),
    .clr_mask(bus_wdata), .en(main_en), .stat(main_stat), .req(main_req)
  );

  irq_status_reg #(.W(DMA_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .clr_go(dma_clr),
    .clr_mask(bus_wdata[DMA_W-1:0]), .en(dma_en), .stat(dma_stat), .req(dma_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      glb_en <= 1'b0;
    else if (bus_wr && (sel == SEL_CTRL) && bus_be[0])
      glb_en <= bus_wdata[0];
  end

  irq_pin_ctl u_pin (
    .clk(clk), .rst_n(rst_n), .req_main(main_req), .req_dma(dma_req),
    .glb_en(glb_en), .asserted(pin_asserted), .irq_n(irq_n)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_MAIN: bus_rdata = main_stat;
      SEL_DMA:  bus_rdata[DMA_W-1:0] = dma_stat;
      SEL_CTRL: bus_rdata[0] = glb_en;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned MAIN_W = 32,
  parameter int unsigned DMA_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MAIN_W-1:0] main_evt,
  input logic [DMA_W-1:0]  dma_evt,
  input logic [MAIN_W-1:0] main_stat,
  input logic [DMA_W-1:0]  dma_stat,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [MAIN_W/8-1:0] bus_be,
  input logic [MAIN_W-1:0] bus_wdata,
  input logic              glb_en,
  input logic              any_req,
  input logic              irq_n
);
  localparam int unsigned DMA_NB = DMA_W / 8;

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|main_evt) |=> ((main_stat & $past(main_evt)) == $past(main_evt)));

  assert_evt_beats_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_evt) |=> ((dma_stat & $past(dma_evt)) == $past(dma_evt)));

  assert_partial_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !(&bus_be) && main_evt == '0) |=> $stable(main_stat));

  assert_partial_dma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !(&bus_be[DMA_NB-1:0]) && dma_evt == '0) |=> $stable(dma_stat));

  assert_w1c_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && (&bus_be) && main_evt == '0)
    |=> ((main_stat & $past(bus_wdata)) == '0) &&
        ((main_stat & ~$past(bus_wdata)) == ($past(main_stat) & ~$past(bus_wdata))));

  assert_gate_asserts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && any_req) |-> !irq_n);

  assert_low_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> any_req);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!irq_n) && any_req) |-> !irq_n);
endmodule

bind irq_aggregator irq_agg_chk #(.MAIN_W(MAIN_W), .DMA_W(DMA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_evt(main_evt), .dma_evt(dma_evt),
  .main_stat(main_stat), .dma_stat(dma_stat), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .glb_en(glb_en), .any_req(any_req), .irq_n(irq_n)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] main_evt = '0, main_en = '0, bus_wdata = '0;
  logic [15:0] dma_evt = '0, dma_en = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .main_evt(main_evt), .dma_evt(dma_evt),
    .main_en(main_en), .dma_en(dma_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0; bus_addr = 2'd3;
  endtask

  task automatic pulse(input logic [31:0] m, input logic [15:0] d);
    @(negedge clk);
    main_evt = m; dma_evt = d;
    @(negedge clk);
    main_evt = '0; dma_evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
    bus_addr = 2'd3;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq_n", {31'd0, irq_n}, 32'd1);
    rd(2'd0, v); check("R1 main", v, 32'd0);
    rd(2'd1, v); check("R1 dma", v, 32'd0);
    rd(2'd2, v); check("R1 ctrl", v, 32'd0);
  endtask

  task automatic t_event_gate_closed;
    logic [31:0] v;
    main_en = '1;
    pulse(32'h1, 16'h0);
    rd(2'd0, v); check("R2 sof bit set", v, 32'h1);
    check("R2 irq_n high", {31'd0, irq_n}, 32'd1);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    pulse(32'h0, 16'h8001);
    rd(2'd1, v); check("R3 dma zero-extended", v, 32'h0000_8001);
  endtask

  task automatic t_gate_open;
    logic [31:0] v;
    wr(2'd2, 4'h1, 32'h1);
    check("R7 irq_n low at once", {31'd0, irq_n}, 32'd0);
    rd(2'd2, v); check("R3 ctrl", v, 32'h1);
  endtask

  task automatic t_sticky;
    wr(2'd2, 4'h1, 32'h0);
    check("R9 still low", {31'd0, irq_n}, 32'd0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(2'd0, 4'hF, 32'h0);
    rd(2'd0, v); check("R4 zero write keeps", v, 32'h1);
    pulse(32'h0000_0F00, 16'h0);
    wr(2'd0, 4'hF, 32'h0000_0100);
    rd(2'd0, v); check("R4 one clears", v, 32'h0000_0E01);
  endtask

  task automatic t_partial;
    logic [31:0] v;
    wr(2'd0, 4'h7, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R5 main partial", v, 32'h0000_0E01);
    wr(2'd1, 4'h1, 32'h0000_FFFF);
    rd(2'd1, v); check("R5 dma partial", v, 32'h0000_8001);
  endtask

  task automatic t_evt_vs_clr;
    logic [31:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_be = 4'hF; bus_wdata = 32'h200;
    main_evt = 32'h200;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0; bus_addr = 2'd3; main_evt = '0;
    rd(2'd0, v); check("R6 event wins", v, 32'h0000_0E01);
  endtask

  task automatic t_release_and_mask;
    logic [31:0] v;
    @(negedge clk); main_en = '0;
    #1 check("R10 released", {31'd0, irq_n}, 32'd1);
    @(negedge clk); main_en = '1;
    @(negedge clk); check("R11 no re-assert", {31'd0, irq_n}, 32'd1);
    main_en = '0;
    wr(2'd2, 4'h1, 32'h1);
    check("R8 masked keeps high", {31'd0, irq_n}, 32'd1);
    rd(2'd0, v); check("R8 status still set", v, 32'h0000_0E01);
    @(negedge clk); dma_en = 16'h0001;
    #1 check("R7 dma asserts", {31'd0, irq_n}, 32'd0);
  endtask

  task automatic t_drain;
    main_en = '1;
    wr(2'd0, 4'hF, 32'hFFFF_FFFF);
    check("R10 dma keeps low", {31'd0, irq_n}, 32'd0);
    wr(2'd2, 4'h1, 32'h0);
    check("R9 sticky dma", {31'd0, irq_n}, 32'd0);
    wr(2'd1, 4'h3, 32'h0000_FFFF);
    check("R10 drained high", {31'd0, irq_n}, 32'd1);
  endtask

  initial begin : wd
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_event_gate_closed();
    t_readback();
    t_gate_open();
    t_sticky();
    t_w1c();
    t_partial();
    t_evt_vs_clr();
    t_release_and_mask();
    t_drain();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule